// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is the datapath of a small stack machine. It takes one instruction at a time over a valid/ready port and has no operand registers that software can name. Two instructions carry a memory address. PUSH loads a word from data memory onto an internal operand stack. POP removes the top word and stores it to memory. The arithmetic instructions ADD, SUB and MULT carry no operand field. Each one takes the two topmost stack entries and replaces them with a single result. Data words are 16-bit two's complement.

The memory port is synchronous and has a read latency of one cycle. While a load is in flight, the instruction port holds ready low. A store and all arithmetic complete in the cycle in which the instruction is accepted. An illegal stack access raises a sticky error flag and leaves the stack contents untouched: pushing onto a full stack is an overflow, and taking more entries than the stack holds is an underflow. A typical use is expression evaluation. The sequence PUSH B, PUSH C, SUB, PUSH D, MULT, POP A writes (B−C)·D to location A and leaves the stack empty.

Top module: `stk_calc_unit`

## Requirements
- R1: PUSH (op code 1) drives a memory read of `instr_addr` in its accept cycle. `instr_ready` is then low for exactly one cycle. After that cycle the word read is on top of the stack and the depth has grown by one.
- R2: POP (op code 2) writes the top entry to memory at `instr_addr` in its accept cycle, removes that entry, and keeps `instr_ready` high.
- R3: ADD (op code 3) replaces the top two entries with their 16-bit wrapping sum and reduces the depth by one.
- R4: SUB (op code 4) replaces the top two entries with (entry below top) minus (top entry), wrapping to 16 bits.
- R5: MULT (op code 5) replaces the top two entries with the low 16 bits of their product.
- R6: Op codes 0, 6 and 7 are accepted without stalling. They do not access memory and change neither the stack nor the flags.
- R7: A PUSH with 8 entries already on the stack sets `ovf_flag`, performs no memory read, and leaves the contents and depth unchanged.
- R8: A POP on an empty stack, or an arithmetic instruction with fewer than two entries, sets `unf_flag`, performs no memory write, and leaves the contents and depth unchanged.
- R9: Both error flags stay set until a synchronous active-high reset. Reset clears both flags and empties the stack.
- R10: The sequence PUSH B, PUSH C, SUB, PUSH D, MULT, POP A stores (B−C)·D, truncated to 16 bits, at A and ends with depth 0.
- R11: `stk_depth` reports the number of occupied entries and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 3 | Op code: 1 PUSH, 2 POP, 3 ADD, 4 SUB, 5 MULT, other values no-op |
| instr_addr | input | 8 | Memory word address for PUSH and POP |
| mem_rd_en | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data, one cycle after `mem_rd_en` |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |
| stk_depth | output | 4 | Number of occupied stack entries |

## Verification
Memory strobes, store address and store data are combinational from an accepted instruction. The bench therefore samples them shortly after it drives the instruction, inside the accept cycle. Depth, flags and arithmetic results change at the accept edge itself, except that a PUSH lands one edge later, after the single ready-low cycle. The bench waits on `instr_ready` at falling edges and counts the stalled cycles, and then checks depth and flags. Stack contents are made visible by POPs into bench memory, which is read one edge after the store is accepted. This is how the untouched state after an error is confirmed.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MULT = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_PUSH,
        ACT_POP,
        ACT_MERGE
    } stk_act_e;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } stk_state_e;

    typedef struct packed {
        logic is_push;
        logic is_pop;
        logic is_arith;
    } stk_dec_t;

    function automatic stk_dec_t stk_decode(input logic [2:0] raw);
        stk_dec_t d;
        d.is_push  = (raw == OP_PUSH);
        d.is_pop   = (raw == OP_POP);
        d.is_arith = (raw == OP_ADD) || (raw == OP_SUB) || (raw == OP_MULT);
        return d;
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_MULT: res = lhs * rhs;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/stk_stack.sv
module stk_stack
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_act_e          act,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] merge_data,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              pair_ok
);
    logic [DATA_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (act == ACT_PUSH && count == CNT_W'(i))
                ent[i] <= push_data;
            else if (act == ACT_MERGE && count == CNT_W'(i + 2))
                ent[i] <= merge_data;
        end
    end

    always_comb begin
        top    = '0;
        second = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count == CNT_W'(i + 1)) top    = ent[i];
            if (count == CNT_W'(i + 2)) second = ent[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_PUSH:  count <= count + CNT_W'(1);
                ACT_POP,
                ACT_MERGE: count <= count - CNT_W'(1);
                default:   count <= count;
            endcase
        end
    end

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign pair_ok = (count >= CNT_W'(2));

    // R11: occupancy stays within capacity
    a_r11_depth_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2: a pop shrinks the stack by exactly one
    a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_POP) |=> (count == $past(count) - CNT_W'(1)));

    // R3: a merge leaves one entry fewer
    a_r3_merge_shrinks: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MERGE) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic              full,
    input  logic              empty,
    input  logic              pair_ok,
    output logic              instr_ready,
    output stk_act_e          act,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ovf_flag,
    output logic              unf_flag
);
    stk_state_e state, state_nx;
    stk_dec_t   dec;
    logic       fire, push_go, pop_go, arith_go, ovf_hit, unf_hit;

    assign dec         = stk_decode(instr_op);
    assign instr_ready = (state == ST_IDLE);
    assign fire        = instr_valid && instr_ready;

    assign push_go  = fire && dec.is_push && !full;
    assign pop_go   = fire && dec.is_pop && !empty;
    assign arith_go = fire && dec.is_arith && pair_ok;
    assign ovf_hit  = fire && dec.is_push && full;
    assign unf_hit  = fire && ((dec.is_pop && empty) || (dec.is_arith && !pair_ok));

    assign mem_rd_en = push_go;
    assign mem_wr_en = pop_go;
    assign mem_addr  = instr_addr;

    always_comb begin
        if (state == ST_FILL)  act = ACT_PUSH;
        else if (pop_go)       act = ACT_POP;
        else if (arith_go)     act = ACT_MERGE;
        else                   act = ACT_HOLD;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (push_go) state_nx = ST_FILL;
            ST_FILL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            state <= state_nx;
            if (ovf_hit) ovf_flag <= 1'b1;
            if (unf_hit) unf_flag <= 1'b1;
        end
    end

    // R1: an issued read stalls the port for the next cycle, which loads the stack
    a_r1_fill_stall: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (!instr_ready && act == ACT_PUSH));

    // R1: the stall never lasts more than one cycle
    a_r1_stall_one: assert property (@(posedge clk) disable iff (rst)
        !instr_ready |=> instr_ready);

    // R9: error flags are sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);
    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag);

    // R2: at most one memory access per cycle
    a_r2_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

// File: rtl/stk_calc_unit.sv
module stk_calc_unit
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [2:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic [CNT_W-1:0]  stk_depth
);
    stk_act_e          act;
    logic [DATA_W-1:0] top, second, alu_res;
    logic              full, empty, pair_ok;

    stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .full        (full),
        .empty       (empty),
        .pair_ok     (pair_ok),
        .instr_ready (instr_ready),
        .act         (act),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_addr    (mem_addr),
        .ovf_flag    (ovf_flag),
        .unf_flag    (unf_flag)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (instr_op),
        .lhs (second),
        .rhs (top),
        .res (alu_res)
    );

    stk_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .push_data  (mem_rdata),
        .merge_data (alu_res),
        .top        (top),
        .second     (second),
        .count      (stk_depth),
        .full       (full),
        .empty      (empty),
        .pair_ok    (pair_ok)
    );

    assign mem_wdata = top;

    // R7: a rejected push leaves the depth unchanged
    a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready && instr_op == 3'd1 && full) |=> $stable(stk_depth));

    // R8: a rejected pop or arithmetic leaves the depth unchanged
    a_r8_short_hold: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready &&
         ((instr_op == 3'd2 && empty) ||
          ((instr_op == 3'd3 || instr_op == 3'd4 || instr_op == 3'd5) && !pair_ok)))
        |=> $stable(stk_depth));
endmodule

// File: tb/stk_calc_unit_tb_top.sv
`timescale 1ns/1ps
module stk_calc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [2:0]  instr_op = 3'd0;
    logic [7:0]  instr_addr = 8'd0;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'd0;
    logic        ovf_flag, unf_flag;
    logic [3:0]  stk_depth;

    logic [15:0] mem [256];
    int n_chk = 0;
    int n_fail = 0;

    logic        s_rd, s_wr, s_rdy;
    logic [15:0] s_wdata;
    logic [7:0]  s_addr;
    int          s_wait;

    always #2 clk = ~clk;

    stk_calc_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
        .stk_depth(stk_depth)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] addr);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = addr;
        #1;
        s_rd = mem_rd_en; s_wr = mem_wr_en; s_rdy = instr_ready;
        s_wdata = mem_wdata; s_addr = mem_addr;
        @(negedge clk);
        instr_valid = 1'b0;
        s_wait = 0;
        while (!instr_ready) begin
            s_wait++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 reset depth", 32'(stk_depth), 0);
        chk("R9 reset ovf", 32'(ovf_flag), 0);
        chk("R9 reset unf", 32'(unf_flag), 0);
        chk("R1 ready after reset", 32'(instr_ready), 1);
    endtask

    task automatic t_push_pop();
        mem[8'h10] = 16'h1234; mem[8'h11] = 16'hBEEF;
        issue(3'd1, 8'h10);
        chk("R1 read strobe", 32'(s_rd), 1);
        chk("R1 read addr", 32'(s_addr), 32'h10);
        chk("R1 one stall cycle", 32'(s_wait), 1);
        chk("R11 depth 1", 32'(stk_depth), 1);
        issue(3'd1, 8'h11);
        chk("R11 depth 2", 32'(stk_depth), 2);
        issue(3'd2, 8'h20);
        chk("R2 write strobe", 32'(s_wr), 1);
        chk("R2 store data", 32'(s_wdata), 32'hBEEF);
        chk("R2 no stall", 32'(s_wait), 0);
        chk("R2 memory", 32'(mem[8'h20]), 32'hBEEF);
        chk("R2 depth", 32'(stk_depth), 1);
        issue(3'd2, 8'h21);
        chk("R2 memory 2", 32'(mem[8'h21]), 32'h1234);
        chk("R11 depth 0", 32'(stk_depth), 0);
    endtask

    task automatic binop(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] exp, input string req);
        mem[8'h30] = a; mem[8'h31] = b;
        issue(3'd1, 8'h30);
        issue(3'd1, 8'h31);
        issue(op, 8'h00);
        chk({req, " no stall"}, 32'(s_wait), 0);
        chk({req, " depth"}, 32'(stk_depth), 1);
        issue(3'd2, 8'h32);
        chk({req, " result"}, 32'(mem[8'h32]), 32'(exp));
    endtask

    task automatic t_arith();
        binop(3'd3, 16'd1000, 16'd234, 16'd1234, "R3 add");
        binop(3'd3, 16'h7FFF, 16'h0001, 16'h8000, "R3 add wrap");
        binop(3'd4, 16'd50, 16'd80, 16'hFFE2, "R4 sub order");
        binop(3'd4, 16'd900, 16'd1, 16'd899, "R4 sub");
        binop(3'd5, 16'd300, 16'd400, 16'd54464, "R5 mult trunc");
        binop(3'd5, 16'hFFFD, 16'd7, 16'hFFEB, "R5 mult neg");
    endtask

    task automatic t_program();
        mem[8'h40] = 16'd5; mem[8'h41] = 16'd9; mem[8'h42] = 16'd7; mem[8'h43] = 16'd0;
        issue(3'd1, 8'h40);
        issue(3'd1, 8'h41);
        issue(3'd4, 8'h00);
        issue(3'd1, 8'h42);
        issue(3'd5, 8'h00);
        issue(3'd2, 8'h43);
        chk("R10 result", 32'(mem[8'h43]), 32'hFFE4);
        chk("R10 empty", 32'(stk_depth), 0);
        chk("R10 no errors", 32'({ovf_flag, unf_flag}), 0);
    endtask

    task automatic t_illegal();
        mem[8'h50] = 16'hAAAA; mem[8'h51] = 16'h5555;
        issue(3'd1, 8'h50);
        issue(3'd1, 8'h51);
        for (int k = 0; k < 3; k++) begin
            issue((k == 0) ? 3'd0 : 3'(k + 5), 8'h52);
            chk("R6 no access", 32'({s_rd, s_wr}), 0);
            chk("R6 no stall", 32'(s_wait), 0);
            chk("R6 depth", 32'(stk_depth), 2);
        end
        chk("R6 flags", 32'({ovf_flag, unf_flag}), 0);
        issue(3'd2, 8'h53);
        chk("R6 top kept", 32'(mem[8'h53]), 32'h5555);
        issue(3'd2, 8'h54);
        chk("R6 second kept", 32'(mem[8'h54]), 32'hAAAA);
    endtask

    task automatic t_overflow();
        int bad = 0;
        do_reset();
        for (int k = 0; k < 8; k++) mem[8'h60 + 8'(k)] = 16'h0100 + 16'(k);
        mem[8'h68] = 16'hDEAD;
        for (int k = 0; k < 8; k++) issue(3'd1, 8'h60 + 8'(k));
        chk("R11 full depth", 32'(stk_depth), 8);
        issue(3'd1, 8'h68);
        chk("R7 no read", 32'(s_rd), 0);
        chk("R7 no stall", 32'(s_wait), 0);
        chk("R7 ovf set", 32'(ovf_flag), 1);
        chk("R7 depth kept", 32'(stk_depth), 8);
        for (int k = 0; k < 8; k++) begin
            issue(3'd2, 8'h70 + 8'(k));
            if (mem[8'h70 + 8'(k)] !== 16'h0107 - 16'(k)) bad++;
        end
        chk("R7 contents kept", 32'(bad), 0);
        chk("R9 ovf sticky", 32'(ovf_flag), 1);
    endtask

    task automatic t_underflow();
        do_reset();
        mem[8'h80] = 16'h0042; mem[8'h81] = 16'h7777;
        issue(3'd2, 8'h81);
        chk("R8 pop empty no write", 32'(s_wr), 0);
        chk("R8 unf set", 32'(unf_flag), 1);
        chk("R8 depth 0", 32'(stk_depth), 0);
        chk("R8 memory kept", 32'(mem[8'h81]), 32'h7777);
        issue(3'd1, 8'h80);
        issue(3'd5, 8'h00);
        chk("R8 arith short depth", 32'(stk_depth), 1);
        issue(3'd2, 8'h82);
        chk("R8 entry kept", 32'(mem[8'h82]), 32'h0042);
        chk("R9 unf sticky", 32'(unf_flag), 1);
        do_reset();
        chk("R9 reset clears", 32'({ovf_flag, unf_flag}), 0);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'd0;
        t_reset();
        t_push_pop();
        t_arith();
        t_program();
        t_illegal();
        t_overflow();
        t_underflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule